// File: doc/BRIEF.md
# Serial Memory Write-Protect Policy

This block decides how a two-wire serial memory answers each addressed command. When the bus front end has received the control byte, it passes in the control nibble, the three device-select bits and the read/write bit. The block then registers whether the device should acknowledge the byte. It also starts or ends an array-write session. When a command programs one of the two software protection flags, the block pulses the matching strobe.

For each data byte of an array write, the front end presents the target word address. One cycle later the block returns a write-allow pulse. The protect pin, when high, denies every byte write and blocks all flag programming. The two software flags, one permanent and one reversible, protect only the lower half of the word-address space. Flag commands use their own control nibble. For these commands the acknowledge bit also reports whether the flag is programmed. The permanent flag is loaded from an init input at reset, so a model reset does not erase it.

Top module: `wpp_policy`

## Requirements
- R1: While `wp_pin` is high during a data byte, `wr_allow` stays low for every word address.
- R2: With `wp_pin` low, when either software flag is programmed, a byte whose address MSB is 0 (lower half) is denied and a byte whose MSB is 1 is allowed. When neither flag is programmed, both halves are allowed.
- R3: Control nibble 4'b1010 is acknowledged exactly when `dev_bits` equals `strap`. Any nibble other than 4'b1010 or 4'b0110 is never acknowledged. Bytes are allowed only inside a session opened by an acknowledged 4'b1010 command with `rw`=0.
- R4: A 4'b0110 write (`rw`=0) with `dev_bits`==`strap` and `a0_hv`=0, while the permanent flag is clear and `wp_pin` is low, is acknowledged and pulses `perm_set_stb`. After that the permanent flag stays set until a reset.
- R5: While the permanent flag is set, no 4'b0110 command of any kind is acknowledged, and no flag strobe is produced.
- R6: The reversible set command is nibble 4'b0110, `dev_bits`=3'b001, `a0_hv`=1, `strap[2:1]`=2'b00, `rw`=0. It is acknowledged and pulses `rev_set_stb` only if the reversible flag is clear. If the flag is already set, it is not acknowledged.
- R7: The reversible clear command is nibble 4'b0110, `dev_bits`=3'b011, `a0_hv`=1, `strap[2]`=0, `strap[1]`=1, `rw`=0. It is always acknowledged (permanent flag clear). It pulses `rev_clr_stb` only if the reversible flag was set.
- R8: A status query is any of the three flag commands with `rw`=1. It is acknowledged exactly when the addressed flag is not programmed, and it produces no strobe.
- R9: While `wp_pin` is high, flag-programming commands get the same acknowledge as with `wp_pin` low, but no strobe fires and no flag changes.
- R10: `ack_en` is updated one cycle after `cmd_valid` and holds until the next command. `wr_allow` is a one-cycle pulse, one cycle after `byte_valid`. Each strobe is a one-cycle pulse, one cycle after `cmd_valid`.
- R11: During reset and after it, `ack_en`, `wr_allow` and the strobes are 0, the reversible flag is clear, and the permanent flag equals `perm_init`.
- R12: A 4'b0110 command that matches none of the three flag patterns is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| perm_init | input | 1 | Permanent flag value loaded at reset |
| cmd_valid | input | 1 | Control byte received this cycle |
| ctrl_nib | input | 4 | Upper control nibble |
| dev_bits | input | 3 | Received device-select bits |
| rw | input | 1 | Read (1) / write (0) bit |
| strap | input | 3 | Device-select strap pins |
| a0_hv | input | 1 | High voltage present on strap bit 0 |
| wp_pin | input | 1 | Protect pin, high protects whole array |
| byte_valid | input | 1 | Data byte received this cycle |
| word_addr | input | ADDR_W | Target word address of the data byte |
| ack_en | output | 1 | Acknowledge the current command |
| wr_allow | output | 1 | Store the data byte (pulse) |
| perm_set_stb | output | 1 | Permanent flag programmed (pulse) |
| rev_set_stb | output | 1 | Reversible flag programmed (pulse) |
| rev_clr_stb | output | 1 | Reversible flag cleared (pulse) |

## Verification
Every result of the block passes through exactly one register. The acknowledge and all three strobes appear one cycle after `cmd_valid`, and the write-allow appears one cycle after `byte_valid`. The bench drives each input on a falling edge, holds it across one rising edge, and samples the outputs on the following falling edge. It drops the input and checks that the pulse outputs are gone one cycle later. Flag state is observed only through the acknowledge of later status queries and through the write-allow of later bytes.

// File: rtl/wpp_pkg.sv
package wpp_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_ARRAY,
    K_PERM,
    K_RSET,
    K_RCLR
  } kind_e;

  localparam logic [3:0] NIB_ARRAY = 4'b1010;
  localparam logic [3:0] NIB_PROT  = 4'b0110;

  // Map a received control byte and pin state onto a command kind.
  function automatic kind_e classify(input logic [3:0] nib,
                                     input logic [2:0] dev,
                                     input logic [2:0] strap,
                                     input logic       hv);
    kind_e k;
    k = K_NONE;
    if (nib == NIB_ARRAY) begin
      if (dev == strap) k = K_ARRAY;
    end else if (nib == NIB_PROT) begin
      if (!hv && dev == strap)                           k = K_PERM;
      else if (hv && dev == 3'b001 && strap[2:1] == 2'b00) k = K_RSET;
      else if (hv && dev == 3'b011 && strap[2:1] == 2'b01) k = K_RCLR;
    end
    return k;
  endfunction

  // Acknowledge decision for a command of kind k against the flag state.
  function automatic logic ack_rule(input kind_e k, input logic rw,
                                    input logic perm, input logic rev);
    case (k)
      K_ARRAY: return 1'b1;
      K_PERM:  return !perm;
      K_RSET:  return !perm && !rev;
      K_RCLR:  return !perm && (rw ? !rev : 1'b1);
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/wpp_decode.sv
module wpp_decode
  import wpp_pkg::*;
(
  input  logic [3:0] ctrl_nib,
  input  logic [2:0] dev_bits,
  input  logic [2:0] strap,
  input  logic       a0_hv,
  output kind_e      kind
);
  assign kind = classify(ctrl_nib, dev_bits, strap, a0_hv);
endmodule

// File: rtl/wpp_flags.sv
module wpp_flags
  import wpp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  perm_init,
  input  logic  cmd_valid,
  input  kind_e kind,
  input  logic  rw,
  input  logic  wp_pin,
  output logic  ack_next,
  output logic  perm_q,
  output logic  rev_q,
  output logic  ack_en,
  output logic  perm_set_stb,
  output logic  rev_set_stb,
  output logic  rev_clr_stb
);
  logic go_pset, go_rset, go_rclr;

  assign ack_next = ack_rule(kind, rw, perm_q, rev_q);
  assign go_pset  = cmd_valid && kind == K_PERM && !rw && !perm_q && !wp_pin;
  assign go_rset  = cmd_valid && kind == K_RSET && !rw && !perm_q && !rev_q && !wp_pin;
  assign go_rclr  = cmd_valid && kind == K_RCLR && !rw && !perm_q && rev_q && !wp_pin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perm_q       <= perm_init;
      rev_q        <= 1'b0;
      ack_en       <= 1'b0;
      perm_set_stb <= 1'b0;
      rev_set_stb  <= 1'b0;
      rev_clr_stb  <= 1'b0;
    end else begin
      if (cmd_valid) ack_en <= ack_next;
      perm_set_stb <= go_pset;
      rev_set_stb  <= go_rset;
      rev_clr_stb  <= go_rclr;
      if (go_pset) perm_q <= 1'b1;
      if (go_rset) rev_q <= 1'b1;
      else if (go_rclr) rev_q <= 1'b0;
    end
  end

  AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(perm_q) && $past(rst_n) |-> perm_q); // R4
  AST_STB_NO_WP: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_set_stb || rev_set_stb || rev_clr_stb) |-> !$past(wp_pin)); // R9
  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({perm_set_stb, rev_set_stb, rev_clr_stb})); // R10
  AST_PERM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_valid && perm_q && kind != K_ARRAY) |-> !ack_en); // R5
endmodule

// File: rtl/wpp_zone.sv
module wpp_zone
  import wpp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  kind_e             kind,
  input  logic              rw,
  input  logic              ack_next,
  input  logic              byte_valid,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              wp_pin,
  input  logic              perm_q,
  input  logic              rev_q,
  output logic              wr_allow
);
  localparam logic [ADDR_W-1:0] HALF = ADDR_W'(1) << (ADDR_W - 1);

  logic sess_q, soft_on, in_low, byte_ok;

  assign soft_on = perm_q || rev_q;
  assign in_low  = word_addr < HALF;
  assign byte_ok = sess_q && !wp_pin && !(soft_on && in_low);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sess_q   <= 1'b0;
      wr_allow <= 1'b0;
    end else begin
      if (cmd_valid) sess_q <= (kind == K_ARRAY) && !rw && ack_next;
      wr_allow <= byte_valid && byte_ok;
    end
  end

  AST_WP_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow |-> !$past(wp_pin)); // R1
  AST_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow && $past(perm_q || rev_q) |-> $past(word_addr[ADDR_W-1])); // R2
  AST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow |-> $past(byte_valid)); // R10
endmodule

// File: rtl/wpp_policy.sv
module wpp_policy
  import wpp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              perm_init,
  input  logic              cmd_valid,
  input  logic [3:0]        ctrl_nib,
  input  logic [2:0]        dev_bits,
  input  logic              rw,
  input  logic [2:0]        strap,
  input  logic              a0_hv,
  input  logic              wp_pin,
  input  logic              byte_valid,
  input  logic [ADDR_W-1:0] word_addr,
  output logic              ack_en,
  output logic              wr_allow,
  output logic              perm_set_stb,
  output logic              rev_set_stb,
  output logic              rev_clr_stb
);
  kind_e kind;
  logic  ack_next, perm_q, rev_q;

  wpp_decode u_dec (
    .ctrl_nib(ctrl_nib), .dev_bits(dev_bits), .strap(strap),
    .a0_hv(a0_hv), .kind(kind)
  );

  wpp_flags u_flags (
    .clk(clk), .rst_n(rst_n), .perm_init(perm_init), .cmd_valid(cmd_valid),
    .kind(kind), .rw(rw), .wp_pin(wp_pin), .ack_next(ack_next),
    .perm_q(perm_q), .rev_q(rev_q), .ack_en(ack_en),
    .perm_set_stb(perm_set_stb), .rev_set_stb(rev_set_stb),
    .rev_clr_stb(rev_clr_stb)
  );

  wpp_zone #(.ADDR_W(ADDR_W)) u_zone (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .kind(kind), .rw(rw),
    .ack_next(ack_next), .byte_valid(byte_valid), .word_addr(word_addr),
    .wp_pin(wp_pin), .perm_q(perm_q), .rev_q(rev_q), .wr_allow(wr_allow)
  );

  AST_FOREIGN_NIB: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_valid && ctrl_nib != NIB_ARRAY && ctrl_nib != NIB_PROT) |-> !ack_en); // R3
endmodule

// File: tb/wpp_policy_test.sv
module wpp_policy_test;
  logic       clk = 1'b0;
  logic       rst_n, perm_init, cmd_valid, rw, a0_hv, wp_pin, byte_valid;
  logic [3:0] ctrl_nib;
  logic [2:0] dev_bits, strap;
  logic [7:0] word_addr;
  logic       ack_en, wr_allow, perm_set_stb, rev_set_stb, rev_clr_stb;
  int         errors = 0, checks = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  wpp_policy #(.ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .perm_init(perm_init), .cmd_valid(cmd_valid),
    .ctrl_nib(ctrl_nib), .dev_bits(dev_bits), .rw(rw), .strap(strap),
    .a0_hv(a0_hv), .wp_pin(wp_pin), .byte_valid(byte_valid),
    .word_addr(word_addr), .ack_en(ack_en), .wr_allow(wr_allow),
    .perm_set_stb(perm_set_stb), .rev_set_stb(rev_set_stb),
    .rev_clr_stb(rev_clr_stb)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic init);
    @(negedge clk);
    rst_n = 1'b0; perm_init = init; cmd_valid = 0; byte_valid = 0;
    rw = 0; a0_hv = 0; wp_pin = 0; ctrl_nib = 0; dev_bits = 0;
    strap = 0; word_addr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Issue one command; returns {ack, perm_set, rev_set, rev_clr} seen next cycle.
  task automatic cmd(input logic [3:0] nib, input logic [2:0] dev,
                     input logic r, input logic hv, output logic [3:0] res);
    ctrl_nib = nib; dev_bits = dev; rw = r; a0_hv = hv; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; a0_hv = 1'b0;
    res = {ack_en, perm_set_stb, rev_set_stb, rev_clr_stb};
    @(negedge clk);
  endtask

  task automatic wbyte(input logic [7:0] a, output logic ok);
    word_addr = a; byte_valid = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0;
    ok = wr_allow;
    @(negedge clk);
    check("R10 wr_allow pulse ends", {3'b0, wr_allow}, 4'h0);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    check("R11 reset outputs", {ack_en, perm_set_stb, rev_set_stb, rev_clr_stb}, 4'h0);
    check("R11 reset wr_allow", {3'b0, wr_allow}, 4'h0);
  endtask

  task automatic t_array;
    logic [3:0] r; logic ok;
    strap = 3'b101;
    cmd(4'b1010, 3'b101, 0, 0, r);
    check("R3 matched array ack", r, 4'b1000);
    check("R10 ack holds", {3'b0, ack_en}, 4'h1);
    wbyte(8'h10, ok); check("R2 unprotected low byte", {3'b0, ok}, 4'h1);
    wbyte(8'hF0, ok); check("R2 unprotected high byte", {3'b0, ok}, 4'h1);
    cmd(4'b1010, 3'b100, 0, 0, r);
    check("R3 mismatched array no ack", r, 4'b0000);
    wbyte(8'hF0, ok); check("R3 byte outside session", {3'b0, ok}, 4'h0);
    cmd(4'b1011, 3'b101, 0, 0, r);
    check("R3 foreign nibble no ack", r, 4'b0000);
    cmd(4'b1010, 3'b101, 1, 0, r);
    wbyte(8'hF0, ok); check("R3 read session denies bytes", {3'b0, ok}, 4'h0);
  endtask

  task automatic t_nomatch;
    logic [3:0] r;
    strap = 3'b000;
    cmd(4'b0110, 3'b111, 0, 0, r); check("R12 stray prot no ack", r, 4'b0000);
    cmd(4'b0110, 3'b101, 0, 1, r); check("R12 hv stray no ack", r, 4'b0000);
  endtask

  task automatic t_wp;
    logic [3:0] r; logic ok;
    wp_pin = 1; strap = 3'b000;
    cmd(4'b0110, 3'b001, 0, 1, r); check("R9 rev set under wp", r, 4'b1000);
    cmd(4'b0110, 3'b000, 0, 0, r); check("R9 perm set under wp", r, 4'b1000);
    cmd(4'b1010, 3'b000, 0, 0, r);
    wbyte(8'h90, ok); check("R1 wp denies high byte", {3'b0, ok}, 4'h0);
    wbyte(8'h05, ok); check("R1 wp denies low byte", {3'b0, ok}, 4'h0);
    wp_pin = 0;
    cmd(4'b0110, 3'b000, 1, 0, r); check("R9 perm still clear", r, 4'b1000);
    cmd(4'b0110, 3'b001, 1, 1, r); check("R9 rev still clear", r, 4'b1000);
  endtask

  task automatic t_rev;
    logic [3:0] r; logic ok;
    strap = 3'b000;
    cmd(4'b0110, 3'b001, 1, 1, r); check("R8 rev query clear", r, 4'b1000);
    cmd(4'b0110, 3'b001, 0, 1, r); check("R6 rev set", r, 4'b1010);
    check("R10 strobe one cycle", {1'b0, perm_set_stb, rev_set_stb, rev_clr_stb}, 4'h0);
    cmd(4'b0110, 3'b001, 0, 1, r); check("R6 rev set again no ack", r, 4'b0000);
    cmd(4'b0110, 3'b001, 1, 1, r); check("R8 rev query set", r, 4'b0000);
    cmd(4'b1010, 3'b000, 0, 0, r);
    wbyte(8'h05, ok); check("R2 rev denies low", {3'b0, ok}, 4'h0);
    wbyte(8'h85, ok); check("R2 rev allows high", {3'b0, ok}, 4'h1);
    strap = 3'b010;
    cmd(4'b0110, 3'b011, 0, 1, r); check("R7 rev clear", r, 4'b1001);
    cmd(4'b0110, 3'b011, 0, 1, r); check("R7 clear of clear flag", r, 4'b1000);
    cmd(4'b1010, 3'b010, 0, 0, r);
    wbyte(8'h05, ok); check("R2 cleared allows low", {3'b0, ok}, 4'h1);
  endtask

  task automatic t_perm;
    logic [3:0] r; logic ok;
    strap = 3'b011;
    cmd(4'b0110, 3'b011, 1, 0, r); check("R8 perm query clear", r, 4'b1000);
    cmd(4'b0110, 3'b011, 0, 0, r); check("R4 perm set", r, 4'b1100);
    cmd(4'b0110, 3'b011, 1, 0, r); check("R5 perm query set", r, 4'b0000);
    cmd(4'b0110, 3'b011, 0, 0, r); check("R5 perm set again", r, 4'b0000);
    strap = 3'b000;
    cmd(4'b0110, 3'b001, 0, 1, r); check("R5 rev set locked", r, 4'b0000);
    cmd(4'b1010, 3'b000, 0, 0, r); check("R3 array still acked", r, 4'b1000);
    wbyte(8'h20, ok); check("R2 perm denies low", {3'b0, ok}, 4'h0);
    wbyte(8'hA0, ok); check("R2 perm allows high", {3'b0, ok}, 4'h1);
  endtask

  task automatic t_init;
    logic [3:0] r;
    do_reset(1'b1);
    strap = 3'b000;
    cmd(4'b0110, 3'b000, 1, 0, r); check("R11 perm loaded from init", r, 4'b0000);
    do_reset(1'b0);
    cmd(4'b0110, 3'b000, 1, 0, r); check("R11 perm clear from init", r, 4'b1000);
  endtask

  initial begin
    t_reset;
    t_array;
    t_nomatch;
    t_wp;
    t_rev;
    t_perm;
    t_init;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule